// File: doc/BRIEF.md
# Core Run-Control Register Block

This block gives a host processor run control over an attached compute core through a small set of 32-bit memory-mapped registers. The host writes one control word that holds a two-bit mode (freeze and soft reset) and a start address. From that word the block derives a halt level for the core. It also produces a single-cycle reset pulse, and at that pulse it loads the program counter the core restarts from. The core is relaunched only when the soft-reset bit is cleared. Setting that bit only parks the core.

The core reports back with two event pulses, one for normal completion and one for a breakpoint fault. Either event freezes the core again and raises pending interrupt bits. Three interrupt lines leave the block. Each line is the AND of its pending bit and its enable bit. The host clears pending bits by writing ones, and it can inject them through a test register. The remaining offsets in the window are decoded, read as zero and discard writes.

Top module: `core_runctl`

## Requirements
- R1: After reset the control word reads 0x3 (freeze and soft reset both set), halt is high, the reset pulse is low, the pending and enable sets are zero and all interrupt outputs are low.
- R2: Reading offset 0x00 returns the pending set in bits [2:0]. Writing offset 0x00 clears each pending bit whose written bit is 1.
- R3: Writing offset 0x08 ORs data bits [2:0] into the pending set. Writing offset 0x04 replaces the enable set with data bits [2:0]. Bit 3 and higher are dropped, and offset 0x08 reads as zero.
- R4: Interrupt outputs follow bit 0 = host request, bit 1 = finish, bit 2 = instruction fault. Each output is high exactly when its pending and enable bits are both set, one cycle after either set changes.
- R5: The control word at offset 0x0C holds the mode in [1:0] (bit 0 freeze, bit 1 soft reset, run = both clear), the start address in [23:2] and a stored flag in [24] that has no effect. Bits [31:25] read as zero.
- R6: A control write that leaves run mode asserts halt, and one that enters run mode releases it. Halt is therefore high exactly when the mode is not run.
- R7: A control write that clears a set soft-reset bit produces a one-cycle reset pulse and loads the start program counter from data bits [23:2]. Every other control write, including one that sets soft reset, leaves the pulse low and the program counter unchanged.
- R8: A completion pulse asserts halt, sets the mode to freeze only (0x1) and sets the finish pending bit.
- R9: A breakpoint pulse asserts halt, sets the mode to freeze only and sets both the finish and instruction-fault pending bits.
- R10: A core event in the same cycle as a host write is not lost. Its pending bits survive a write-1-to-clear of the same bits, and its freeze overrides the mode written by a simultaneous control write.
- R11: Offsets 0x10 to 0x20 and every other unmapped offset in the 0x1000-byte window read as zero, and writes to them change nothing. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable (0 = read) |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| core_done | input | 1 | Completion event pulse from the core |
| core_brk | input | 1 | Breakpoint fault event pulse from the core |
| core_halt | output | 1 | Halt level to the core |
| core_rst_pulse | output | 1 | One-cycle core reset |
| core_start_pc | output | 22 | Program counter the core restarts from |
| irq_host | output | 1 | Host request interrupt |
| irq_finish | output | 1 | Finish interrupt |
| irq_fault | output | 1 | Instruction fault interrupt |

## Verification
The assertions check several properties on every cycle. Halt must always agree with the stored mode. The reset pulse must never last two cycles, and the start program counter may move only with that pulse. Every core event must leave its pending bits set on the next cycle. Interrupt lines must match pending AND enable, and the host-request bit may appear only through a test write. Other behaviours are visible only at the register interface, so only the directed scenarios show them. These are: that soft reset rising does not relaunch the core, the field layout of the control word, the replacement of a written mode by a simultaneous event, and the zero reads of the reserved offsets.

// File: rtl/core_runctl_pkg.sv
package core_runctl_pkg;
  localparam int IRQ_N    = 3;
  localparam int IRQ_HOST = 0;
  localparam int IRQ_FIN  = 1;
  localparam int IRQ_FLT  = 2;

  localparam int OFF_ISTATE = 'h00;
  localparam int OFF_IEN    = 'h04;
  localparam int OFF_ITEST  = 'h08;
  localparam int OFF_CTRL   = 'h0C;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_FRZ  = 2'b01,
    MODE_SRST = 2'b10,
    MODE_HOLD = 2'b11
  } mode_e;
endpackage

// File: rtl/core_runctl_irq.sv
module core_runctl_irq
  import core_runctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic             test_we,
  input  logic             clr_we,
  input  logic [IRQ_N-1:0] wbits,
  input  logic             ev_done,
  input  logic             ev_brk,
  output logic [IRQ_N-1:0] pend_q,
  output logic [IRQ_N-1:0] en_q,
  output logic [IRQ_N-1:0] irq_q
);
  logic [IRQ_N-1:0] ev_set, pend_nxt, en_nxt;

  always_comb begin
    ev_set = '0;
    if (ev_done) ev_set[IRQ_FIN] = 1'b1;
    if (ev_brk) begin
      ev_set[IRQ_FIN] = 1'b1;
      ev_set[IRQ_FLT] = 1'b1;
    end
    pend_nxt = pend_q;
    if (clr_we)  pend_nxt = pend_nxt & ~wbits;
    if (test_we) pend_nxt = pend_nxt | wbits;
    pend_nxt = pend_nxt | ev_set;  // events win over a same-cycle clear
    en_nxt = en_we ? wbits : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      en_q   <= en_nxt;
      irq_q  <= pend_nxt & en_nxt;
    end
  end

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q & en_q));
  // R8
  done_sets_fin_chk: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> pend_q[IRQ_FIN]);
  // R9
  brk_sets_flt_chk: assert property (@(posedge clk) disable iff (rst)
    ev_brk |=> (pend_q[IRQ_FIN] && pend_q[IRQ_FLT]));
  // R3
  host_only_by_test_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q[IRQ_HOST]) |-> $past(test_we && wbits[IRQ_HOST]));
endmodule

// File: rtl/core_runctl_mode.sv
module core_runctl_mode
  import core_runctl_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  mode_e           mode_new,
  input  logic [PC_W-1:0] addr_new,
  input  logic            vsel_new,
  input  logic            ev_stop,
  output mode_e           mode_q,
  output logic [PC_W-1:0] addr_q,
  output logic            vsel_q,
  output logic            halt_q,
  output logic            rst_pulse_q,
  output logic [PC_W-1:0] start_pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_HOLD;
      addr_q      <= '0;
      vsel_q      <= 1'b0;
      halt_q      <= 1'b1;
      rst_pulse_q <= 1'b0;
      start_pc_q  <= '0;
    end else begin
      rst_pulse_q <= 1'b0;
      if (ctrl_we) begin
        addr_q <= addr_new;
        vsel_q <= vsel_new;
        mode_q <= mode_new;
        if (mode_q == MODE_RUN && mode_new != MODE_RUN) halt_q <= 1'b1;
        if (mode_q != MODE_RUN && mode_new == MODE_RUN) halt_q <= 1'b0;
        if (mode_q[1] && !mode_new[1]) begin
          rst_pulse_q <= 1'b1;
          start_pc_q  <= addr_new;
        end
      end
      if (ev_stop) begin
        mode_q <= MODE_FRZ;
        halt_q <= 1'b1;
      end
    end
  end

  // R6
  halt_mode_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q == (mode_q != MODE_RUN));
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse_q |=> !rst_pulse_q);
  // R7
  pc_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_pulse_q |-> $stable(start_pc_q));
endmodule

// File: rtl/core_runctl.sv
module core_runctl
  import core_runctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PC_W   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              core_done,
  input  logic              core_brk,
  output logic              core_halt,
  output logic              core_rst_pulse,
  output logic [PC_W-1:0]   core_start_pc,
  output logic              irq_host,
  output logic              irq_finish,
  output logic              irq_fault
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int PC_LSB   = 2;
  localparam int PC_MSB   = PC_LSB + PC_W - 1;
  localparam int VSEL_BIT = PC_MSB + 1;
  localparam logic [WORD_W-1:0] W_ISTATE = WORD_W'(OFF_ISTATE >> 2);
  localparam logic [WORD_W-1:0] W_IEN    = WORD_W'(OFF_IEN >> 2);
  localparam logic [WORD_W-1:0] W_ITEST  = WORD_W'(OFF_ITEST >> 2);
  localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(OFF_CTRL >> 2);

  logic [WORD_W-1:0] word;
  logic              wr, rd;
  logic [IRQ_N-1:0]  pend, en, irq;
  mode_e             mode;
  logic [PC_W-1:0]   ctrl_addr;
  logic              vsel;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign word = bus_addr[ADDR_W-1:2];
  assign wr   = bus_valid & bus_we;
  assign rd   = bus_valid & ~bus_we;
  assign unused_bits = ^{bus_wdata[DATA_W-1:VSEL_BIT+1], bus_wdata[IRQ_N +: (PC_LSB + PC_W - IRQ_N)],
                         bus_addr[1:0]};

  core_runctl_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .en_we   (wr && word == W_IEN),
    .test_we (wr && word == W_ITEST),
    .clr_we  (wr && word == W_ISTATE),
    .wbits   (bus_wdata[IRQ_N-1:0]),
    .ev_done (core_done),
    .ev_brk  (core_brk),
    .pend_q  (pend),
    .en_q    (en),
    .irq_q   (irq)
  );

  core_runctl_mode #(.PC_W(PC_W)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .ctrl_we     (wr && word == W_CTRL),
    .mode_new    (mode_e'(bus_wdata[1:0])),
    .addr_new    (bus_wdata[PC_MSB:PC_LSB]),
    .vsel_new    (bus_wdata[VSEL_BIT]),
    .ev_stop     (core_done | core_brk),
    .mode_q      (mode),
    .addr_q      (ctrl_addr),
    .vsel_q      (vsel),
    .halt_q      (core_halt),
    .rst_pulse_q (core_rst_pulse),
    .start_pc_q  (core_start_pc)
  );

  always_comb begin
    rd_mux = '0;
    if (word == W_ISTATE) rd_mux[IRQ_N-1:0] = pend;
    else if (word == W_IEN) rd_mux[IRQ_N-1:0] = en;
    else if (word == W_CTRL) begin
      rd_mux[1:0]           = mode;
      rd_mux[PC_MSB:PC_LSB] = ctrl_addr;
      rd_mux[VSEL_BIT]      = vsel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  assign irq_host   = irq[IRQ_HOST];
  assign irq_finish = irq[IRQ_FIN];
  assign irq_fault  = irq[IRQ_FLT];

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_core_runctl.sv
module test_core_runctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_done = 1'b0, core_brk = 1'b0;
  logic        core_halt, core_rst_pulse;
  logic [21:0] core_start_pc;
  logic        irq_host, irq_finish, irq_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_runctl i_core_runctl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_done(core_done), .core_brk(core_brk), .core_halt(core_halt),
    .core_rst_pulse(core_rst_pulse), .core_start_pc(core_start_pc),
    .irq_host(irq_host), .irq_finish(irq_finish), .irq_fault(irq_fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // write, optionally together with core events; returns right after the edge
  task automatic wr_ev(input logic [11:0] a, input logic [31:0] d,
                       input logic dn, input logic bk);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    core_done = dn; core_brk = bk;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; core_done = 1'b0; core_brk = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_ev(a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic event_pulse(input logic dn, input logic bk);
    @(negedge clk);
    core_done = dn; core_brk = bk;
    @(negedge clk);
    core_done = 1'b0; core_brk = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 halt", 32'(core_halt), 1);
    chk("R1 pulse", 32'(core_rst_pulse), 0);
    chk("R1 irqs", {29'd0, irq_fault, irq_finish, irq_host}, 0);
    rd(12'h00C, v); chk("R1 ctrl", v, 32'h3);
    rd(12'h000, v); chk("R1 pend", v, 0);
    rd(12'h004, v); chk("R1 en", v, 0);
  endtask

  task automatic t_launch();
    logic [31:0] v;
    wr(12'h00C, 32'h2);
    chk("R7 no pulse freeze clear", 32'(core_rst_pulse), 0);
    chk("R6 still halted", 32'(core_halt), 1);
    wr(12'h00C, 32'h1234 << 2);
    chk("R7 pulse on fall", 32'(core_rst_pulse), 1);
    chk("R7 pc load", 32'(core_start_pc), 32'h1234);
    chk("R6 run releases", 32'(core_halt), 0);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(core_rst_pulse), 0);
    rd(12'h00C, v); chk("R5 ctrl readback", v, 32'h48D0);
  endtask

  task automatic t_srst_rise();
    wr(12'h00C, (32'h1234 << 2) | 32'h2);
    chk("R6 leave run halts", 32'(core_halt), 1);
    chk("R7 rise no pulse", 32'(core_rst_pulse), 0);
    wr(12'h00C, 32'h55 << 2);
    chk("R7 fall pulse", 32'(core_rst_pulse), 1);
    chk("R7 new pc", 32'(core_start_pc), 32'h55);
    chk("R6 run again", 32'(core_halt), 0);
  endtask

  task automatic t_freeze();
    wr(12'h00C, (32'h77 << 2) | 32'h1);
    chk("R6 freeze halts", 32'(core_halt), 1);
    chk("R7 freeze no pulse", 32'(core_rst_pulse), 0);
    wr(12'h00C, 32'h77 << 2);
    chk("R6 unfreeze", 32'(core_halt), 0);
    chk("R7 unfreeze no pulse", 32'(core_rst_pulse), 0);
    chk("R7 pc kept", 32'(core_start_pc), 32'h55);
  endtask

  task automatic t_irq_regs();
    logic [31:0] v;
    wr(12'h004, 32'hF);
    rd(12'h004, v); chk("R3 en masked", v, 32'h7);
    wr(12'h008, 32'h9);
    rd(12'h000, v); chk("R3 test sets host", v, 32'h1);
    chk("R4 host irq", {29'd0, irq_fault, irq_finish, irq_host}, 32'h1);
    rd(12'h008, v); chk("R3 test reads zero", v, 0);
    wr(12'h000, 32'h1);
    rd(12'h000, v); chk("R2 w1c", v, 0);
    chk("R4 host low", 32'(irq_host), 0);
    wr(12'h004, 32'h0);
    wr(12'h008, 32'h7);
    chk("R4 masked all", {29'd0, irq_fault, irq_finish, irq_host}, 0);
    rd(12'h000, v); chk("R2 pend all", v, 32'h7);
    wr(12'h000, 32'h5);
    rd(12'h000, v); chk("R2 partial clear", v, 32'h2);
    wr(12'h000, 32'h7);
    wr(12'h004, 32'h7);
  endtask

  task automatic t_done();
    logic [31:0] v;
    event_pulse(1'b1, 1'b0);
    chk("R8 halt", 32'(core_halt), 1);
    chk("R8 irqs", {29'd0, irq_fault, irq_finish, irq_host}, 32'h2);
    rd(12'h00C, v); chk("R8 mode freeze", v, 32'h1DD);
    rd(12'h000, v); chk("R8 pend", v, 32'h2);
    wr(12'h000, 32'h2);
    wr(12'h00C, 32'h1DC);
    chk("R6 resume", 32'(core_halt), 0);
    chk("R7 resume no pulse", 32'(core_rst_pulse), 0);
  endtask

  task automatic t_brk();
    logic [31:0] v;
    event_pulse(1'b0, 1'b1);
    chk("R9 halt", 32'(core_halt), 1);
    chk("R9 irqs", {29'd0, irq_fault, irq_finish, irq_host}, 32'h6);
    rd(12'h000, v); chk("R9 pend", v, 32'h6);
    rd(12'h00C, v); chk("R9 mode freeze", v, 32'h1DD);
    wr(12'h000, 32'h6);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(12'h00C, 32'h1DC);
    wr(12'h008, 32'h2);
    wr_ev(12'h000, 32'h2, 1'b1, 1'b0);
    rd(12'h000, v); chk("R10 event beats clear", v, 32'h2);
    chk("R10 halt", 32'(core_halt), 1);
    wr_ev(12'h00C, 32'h1DC, 1'b1, 1'b0);
    rd(12'h00C, v); chk("R10 event beats ctrl", v, 32'h1DD);
    chk("R10 halt kept", 32'(core_halt), 1);
    wr(12'h000, 32'h7);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    for (int a = 'h10; a <= 'h20; a += 4) begin
      wr(12'(a), 32'hFFFF_FFFF);
      rd(12'(a), v); chk("R11 reserved zero", v, 0);
    end
    rd(12'h400, v); chk("R11 unmapped zero", v, 0);
    rd(12'h00C, v); chk("R11 ctrl untouched", v, 32'h1DD);
    rd(12'h004, v); chk("R11 en untouched", v, 32'h7);
    chk("R11 halt untouched", 32'(core_halt), 1);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] v;
    wr(12'h00C, 32'hFFFF_FFFF);
    chk("R7 hold no pulse", 32'(core_rst_pulse), 0);
    rd(12'h00C, v); chk("R5 field mask", v, 32'h01FF_FFFF);
    chk("R5 pc unchanged", 32'(core_start_pc), 32'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_launch();
    t_srst_rise();
    t_freeze();
    t_irq_regs();
    t_done();
    t_brk();
    t_collide();
    t_reserved();
    t_ctrl_fields();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule